// File: doc/BRIEF.md
# Event Performance Monitor

This block watches a processor and counts cycles and selected events. It has one cycle counter and two 32-bit event counters. Each event counter is tied to one of several single-cycle event strobes that arrive from outside. An 8-bit code chosen by software picks the strobe. Code value c selects strobe line c. A small word-addressed register bus reads and writes a packed control word and the three counters. Software can preload any counter so that it wraps after a chosen number of events.

Wrapping from all-ones to zero sets a sticky flag for that counter. A flag is cleared by writing one to its bit. A single interrupt line is raised while any flag is set and its interrupt enable is also set. The cycle counter can run at full clock rate or once every 64 clocks. The code 0xFF parks an event counter so that it does not count. At reset both codes hold this value.

Top module: `pmu_event_monitor`

## Requirements
- R1: Control bit 0 is the run enable. While it is 0, no counter changes except by a direct write or a reset bit.
- R2: Event counter 0 takes its code from control bits 19:12, and event counter 1 takes its code from bits 27:20. On each clock with run enable set, a counter adds 1 if the strobe line numbered by its code is high. Strobes on other lines have no effect on it.
- R3: A code of 0xFF, or any code at or above the number of strobe lines (24), never counts. Both codes reset to 0xFF, so after reset the control word reads 0x0FFFF000.
- R4: Writing control with bit 1 set zeroes both event counters. Writing control with bit 2 set zeroes the cycle counter and its divider. Both bits read back as 0.
- R5: With run enable set, the cycle counter adds 1 every clock. When control bit 3 is also set, it adds 1 once every 64 enabled clocks.
- R6: A write to address 1, 2 or 3 loads the cycle counter, event counter 0 or event counter 1. In the same cycle, the write wins over both an increment and a reset bit.
- R7: When a counter wraps from 0xFFFFFFFF to 0, a sticky flag is set: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter.
- R8: A control write clears each flag whose bit is written as 1. A 0 in that bit leaves the flag unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R9: The irq output is high while any flag is set together with its enable. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter.
- R10: The read data follows the address without a clock. Address 0 returns the control word, with unused bits read as 0. Addresses 1, 2 and 3 return the cycle counter, event counter 0 and event counter 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWr | input | 1 | Write strobe for the addressed register |
| busAddr | input | 2 | Register select: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| evtIn | input | NUM_EVT | Single-cycle event strobes, one per code value |
| irq | output | 1 | Interrupt: any enabled overflow flag set |

## Verification
The assertions check the following on every cycle:
- Counters hold while the run enable is clear.
- A parked counter does not move.
- A direct write lands exactly as written.
- A wrap always sets its flag, and the flag stays set until it is cleared by a write.
- An enabled wrap raises irq.

The bench scenarios cover the rest:
- Which strobe line each code picks.
- That unassigned codes count nothing.
- The exact 64-clock divider period.
- The reset bits reading back as zero.
- The wrap-against-clear race.
- The full control-word readback.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_PARK = 8'hFF;

  // Strobes from the control side to the counting datapath.
  typedef struct packed {
    logic                         enable;
    logic                         div64;
    logic                         evRst;
    logic                         cycRst;
    logic                         wrCyc;
    logic [1:0]                   wrEv;
    logic [DATA_W-1:0]            wdata;
    logic [1:0][CODE_W-1:0]       code;
  } strobe_t;
endpackage

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 24,
  parameter int PRESCALE = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [NUM_EVT-1:0]     evtIn,
  output logic [DATA_W-1:0]      cycCnt,
  output logic [1:0][DATA_W-1:0] evCnt,
  output logic [2:0]             wrapPulse   // {cycle, event1, event0}
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] preCnt;
  logic          cycTick;
  logic          cycInc;

  assign cycTick = !strb.div64 || (preCnt == PRE_LAST);
  assign cycInc  = strb.enable && cycTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         preCnt <= '0;
    else if (strb.cycRst || !strb.div64) preCnt <= '0;
    else if (strb.enable)              preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cycCnt <= '0;
    else if (strb.wrCyc)   cycCnt <= strb.wdata;
    else if (strb.cycRst)  cycCnt <= '0;
    else if (cycInc)       cycCnt <= cycCnt + 1'b1;
  end

  assign wrapPulse[2] = cycInc && !strb.wrCyc && !strb.cycRst && (cycCnt == '1);

  for (genvar g = 0; g < 2; g++) begin : g_evt
    logic hit;
    logic evInc;

    always_comb begin
      hit = 1'b0;
      for (int e = 0; e < NUM_EVT; e++) begin
        if (strb.code[g] == CODE_W'(e) && strb.code[g] != CODE_PARK) hit = evtIn[e];
      end
    end

    assign evInc = strb.enable && hit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               evCnt[g] <= '0;
      else if (strb.wrEv[g])   evCnt[g] <= strb.wdata;
      else if (strb.evRst)     evCnt[g] <= '0;
      else if (evInc)          evCnt[g] <= evCnt[g] + 1'b1;
    end

    assign wrapPulse[g] = evInc && !strb.wrEv[g] && !strb.evRst && (evCnt[g] == '1);

    // R1: a disabled event counter only moves by write or reset
    p_hold_event_r1: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.enable && !strb.wrEv[g] && !strb.evRst) |=> $stable(evCnt[g]));

    // R3: a parked counter never advances
    p_parked_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.code[g] == CODE_PARK && !strb.wrEv[g] && !strb.evRst) |=> $stable(evCnt[g]));

    // R6: a direct write lands exactly as written
    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrEv[g] |=> (evCnt[g] == $past(strb.wdata)));
  end

  // R1: a disabled cycle counter only moves by write or reset
  p_hold_cycle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.enable && !strb.wrCyc && !strb.cycRst) |=> $stable(cycCnt));

  // R4: cycle reset bit zeroes the cycle counter unless a write overrides it
  p_cyc_reset_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cycRst && !strb.wrCyc) |=> (cycCnt == '0));
endmodule

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWr,
  input  logic [1:0]             busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  input  logic [DATA_W-1:0]      cycCnt,
  input  logic [1:0][DATA_W-1:0] evCnt,
  input  logic [2:0]             wrapPulse,
  output strobe_t                strb,
  output logic                   irq
);
  logic                   runEn;
  logic                   divMode;
  logic [2:0]             intEn;    // {cycle, event1, event0}
  logic [2:0]             ovfFlag;  // {cycle, event1, event0}
  logic [1:0][CODE_W-1:0] evCode;
  logic                   ctrlWr;
  logic [2:0]             clrMask;

  assign ctrlWr  = busWr && (busAddr == 2'd0);
  assign clrMask = ctrlWr ? busWdata[10:8] : 3'b000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      divMode <= 1'b0;
      intEn   <= '0;
      evCode  <= {CODE_PARK, CODE_PARK};
    end else if (ctrlWr) begin
      runEn     <= busWdata[0];
      divMode   <= busWdata[3];
      intEn     <= busWdata[6:4];
      evCode[0] <= busWdata[19:12];
      evCode[1] <= busWdata[27:20];
    end
  end

  // A wrap in the same cycle as a clear keeps the flag set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= '0;
    else       ovfFlag <= (ovfFlag & ~clrMask) | wrapPulse;
  end

  always_comb begin
    strb.enable = runEn;
    strb.div64  = divMode;
    strb.evRst  = ctrlWr && busWdata[1];
    strb.cycRst = ctrlWr && busWdata[2];
    strb.wrCyc  = busWr && (busAddr == 2'd1);
    strb.wrEv   = {busWr && (busAddr == 2'd3), busWr && (busAddr == 2'd2)};
    strb.wdata  = busWdata;
    strb.code   = evCode;
  end

  always_comb begin
    unique case (busAddr)
      2'd0: busRdata = {4'b0, evCode[1], evCode[0], 1'b0, ovfFlag, 1'b0,
                        intEn, divMode, 2'b00, runEn};
      2'd1: busRdata = cycCnt;
      2'd2: busRdata = evCnt[0];
      default: busRdata = evCnt[1];
    endcase
  end

  assign irq = |(ovfFlag & intEn);

  for (genvar i = 0; i < 3; i++) begin : g_chk
    // R7: a wrap always sets its flag
    p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
      wrapPulse[i] |=> ovfFlag[i]);
    // R7: a set flag stays set unless written with a 1
    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      (ovfFlag[i] && !(ctrlWr && busWdata[8+i])) |=> ovfFlag[i]);
    // R8: a clear without a racing wrap empties the flag
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlWr && busWdata[8+i] && !wrapPulse[i]) |=> !ovfFlag[i]);
    // R9: an enabled wrap raises the interrupt
    p_irq_raise_r9: assert property (@(posedge clk) disable iff (!rstN)
      (wrapPulse[i] && intEn[i] && !ctrlWr) |=> irq);
  end
endmodule

// File: rtl/pmu_event_monitor.sv
module pmu_event_monitor
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 24,
  parameter int PRESCALE = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWr,
  input  logic [1:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic               irq
);
  strobe_t                strb;
  logic [DATA_W-1:0]      cycCnt;
  logic [1:0][DATA_W-1:0] evCnt;
  logic [2:0]             wrapPulse;

  pmu_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .cycCnt    (cycCnt),
    .evCnt     (evCnt),
    .wrapPulse (wrapPulse),
    .strb      (strb),
    .irq       (irq)
  );

  pmu_datapath #(.NUM_EVT(NUM_EVT), .PRESCALE(PRESCALE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .evtIn     (evtIn),
    .cycCnt    (cycCnt),
    .evCnt     (evCnt),
    .wrapPulse (wrapPulse)
  );
endmodule

// File: tb/pmu_event_monitor_test.sv
module pmu_event_monitor_test;
  localparam int NE = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWr = 1'b0;
  logic [1:0]    busAddr = 2'd0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NE-1:0] evtIn = '0;
  logic          irq;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  pmu_event_monitor #(.NUM_EVT(NE), .PRESCALE(64)) uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn), .irq(irq)
  );

  always #10 clk = ~clk;  // 50 MHz

  // kind: 0 write, 1 strobe events for n clocks, 2 check read
  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  req;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [23:0] evt;
    logic [7:0]  n;
  } op_t;

  localparam int NV = 28;
  localparam op_t VEC [NV] = '{
    '{2'd0, 4'd6,  2'd2, 32'h0,        24'h0,      8'd0},
    '{2'd0, 4'd6,  2'd3, 32'h0,        24'h0,      8'd0},
    '{2'd0, 4'd2,  2'd0, 32'h00B07001, 24'h0,      8'd0},
    '{2'd1, 4'd2,  2'd0, 32'h0,        24'h000080, 8'd5},
    '{2'd2, 4'd2,  2'd2, 32'd5,        24'h0,      8'd0},  // R2
    '{2'd2, 4'd2,  2'd3, 32'd0,        24'h0,      8'd0},  // R2
    '{2'd1, 4'd2,  2'd0, 32'h0,        24'h000880, 8'd3},
    '{2'd2, 4'd2,  2'd2, 32'd8,        24'h0,      8'd0},  // R2
    '{2'd2, 4'd2,  2'd3, 32'd3,        24'h0,      8'd0},  // R2
    '{2'd1, 4'd2,  2'd0, 32'h0,        24'hFFF77F, 8'd4},
    '{2'd2, 4'd2,  2'd2, 32'd8,        24'h0,      8'd0},  // R2 other lines ignored
    '{2'd2, 4'd2,  2'd3, 32'd3,        24'h0,      8'd0},  // R2
    '{2'd0, 4'd1,  2'd0, 32'h00B07000, 24'h0,      8'd0},
    '{2'd1, 4'd1,  2'd0, 32'h0,        24'hFFFFFF, 8'd4},
    '{2'd2, 4'd1,  2'd2, 32'd8,        24'h0,      8'd0},  // R1
    '{2'd2, 4'd1,  2'd3, 32'd3,        24'h0,      8'd0},  // R1
    '{2'd0, 4'd4,  2'd0, 32'h00B07003, 24'h0,      8'd0},
    '{2'd2, 4'd4,  2'd2, 32'd0,        24'h0,      8'd0},  // R4
    '{2'd2, 4'd4,  2'd3, 32'd0,        24'h0,      8'd0},  // R4
    '{2'd2, 4'd4,  2'd0, 32'h00B07001, 24'h0,      8'd0},  // R4 reads back 0
    '{2'd0, 4'd3,  2'd0, 32'h0FF07001, 24'h0,      8'd0},
    '{2'd1, 4'd3,  2'd0, 32'h0,        24'hFFFFFF, 8'd2},
    '{2'd2, 4'd3,  2'd2, 32'd2,        24'h0,      8'd0},  // R3
    '{2'd2, 4'd3,  2'd3, 32'd0,        24'h0,      8'd0},  // R3 parked
    '{2'd0, 4'd3,  2'd0, 32'h03007001, 24'h0,      8'd0},
    '{2'd1, 4'd3,  2'd0, 32'h0,        24'hFFFFFF, 8'd2},
    '{2'd2, 4'd3,  2'd2, 32'd4,        24'h0,      8'd0},  // R3
    '{2'd2, 4'd3,  2'd3, 32'd0,        24'h0,      8'd0}   // R3 unassigned
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wrEv(input logic [1:0] a, input logic [31:0] d, input logic [NE-1:0] e);
    busWr = 1'b1; busAddr = a; busWdata = d; evtIn = e;
    @(negedge clk);
    busWr = 1'b0; evtIn = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEv(a, d, '0);
  endtask

  task automatic strobe(input logic [NE-1:0] e, input int n);
    evtIn = e;
    repeat (n) @(negedge clk);
    evtIn = '0;
  endtask

  task automatic rd(input int req, input logic [1:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: R3 parked codes, R10 readback
    rd(3, 2'd0, 32'h0FFFF000);
    rd(10, 2'd1, 32'd0);
    rd(10, 2'd2, 32'd0);
    rd(10, 2'd3, 32'd0);
    check(9, {31'd0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: strobe(VEC[i].evt, int'(VEC[i].n));
        default: rd(int'(VEC[i].req), VEC[i].addr, VEC[i].data);
      endcase
    end

    // R7 event 0 wrap with preload
    wr(2'd0, 32'h0);
    wr(2'd2, 32'hFFFFFFFE);
    wr(2'd0, 32'h00007011);
    strobe(24'h80, 1);
    rd(7, 2'd2, 32'hFFFFFFFF);
    check(9, {31'd0, irq}, 32'd0);
    strobe(24'h80, 1);
    rd(7, 2'd2, 32'd0);
    rd(7, 2'd0, 32'h00007111);
    check(9, {31'd0, irq}, 32'd1);
    // R8 writing 0 leaves flag, writing 1 clears
    wr(2'd0, 32'h00007011);
    rd(8, 2'd0, 32'h00007111);
    check(8, {31'd0, irq}, 32'd1);
    wr(2'd0, 32'h00007111);
    rd(8, 2'd0, 32'h00007011);
    check(8, {31'd0, irq}, 32'd0);
    // R8 wrap racing a clear keeps the flag
    wr(2'd2, 32'hFFFFFFFF);
    wrEv(2'd0, 32'h00007111, 24'h80);
    rd(8, 2'd0, 32'h00007111);
    rd(8, 2'd2, 32'd0);
    // R9 masked flag, then enable raises irq
    wr(2'd0, 32'h00007101);
    wr(2'd2, 32'hFFFFFFFF);
    strobe(24'h80, 1);
    check(9, {31'd0, irq}, 32'd0);
    rd(9, 2'd0, 32'h00007101);
    wr(2'd0, 32'h00007011);
    check(9, {31'd0, irq}, 32'd1);
    wr(2'd0, 32'h00000100);
    // R6 write wins over increment
    wr(2'd0, 32'h00007001);
    wr(2'd2, 32'd5);
    wrEv(2'd2, 32'h00001234, 24'h80);
    rd(6, 2'd2, 32'h00001234);
    // R6 write wins over reset bit (write ev1 while resetting through ctrl is not one port; check cycle)
    // R7 event 1 wrap, bit 9
    wr(2'd0, 32'h00B00021);
    wr(2'd3, 32'hFFFFFFFF);
    strobe(24'h800, 1);
    rd(7, 2'd3, 32'd0);
    rd(7, 2'd0, 32'h00B00221);
    check(9, {31'd0, irq}, 32'd1);
    wr(2'd0, 32'h00000200);
    // R5 cycle counter at full rate
    wr(2'd1, 32'd100);
    wr(2'd0, 32'h00000001);
    rd(5, 2'd1, 32'd100);
    repeat (10) @(negedge clk);
    rd(5, 2'd1, 32'd110);
    wr(2'd0, 32'h00000005);
    rd(4, 2'd1, 32'd0);
    @(negedge clk);
    rd(5, 2'd1, 32'd1);
    // R5 divide-by-64
    wr(2'd0, 32'h00000004);
    rd(4, 2'd1, 32'd0);
    wr(2'd0, 32'h00000009);
    repeat (63) @(negedge clk);
    rd(5, 2'd1, 32'd0);
    @(negedge clk);
    rd(5, 2'd1, 32'd1);
    repeat (64) @(negedge clk);
    rd(5, 2'd1, 32'd2);
    // R7 cycle wrap, bit 10, irq via bit 6
    wr(2'd0, 32'h00000000);
    wr(2'd1, 32'hFFFFFFFF);
    wr(2'd0, 32'h00000041);
    rd(7, 2'd1, 32'hFFFFFFFF);
    @(negedge clk);
    rd(7, 2'd1, 32'd0);
    rd(10, 2'd0, 32'h00000441);
    check(9, {31'd0, irq}, 32'd1);

    done = 1'b1;
    summary();
  end
endmodule